// File: doc/BRIEF.md
# Multi-Channel Serial Interrupt Arbiter

This block merges the interrupt requests of four serial channels (a transmit, a receive and a change-of-state request per channel) and of one counter/timer into a single active-low request line for a host processor. Each request is gated by an enable bit in one of two write-only mask registers, one mask register per pair of channels. Every enabled, pending request places a bid built from a programmable per-channel level and a fixed type code; the highest bid wins, and the line is driven low only while the winner's level is strictly above a programmable threshold.

The host finds out who is interrupting by reading a source register. That register is not live: it is reloaded only when the host writes any value to the update command address 0x2A or pulses the acknowledge input, and it then captures the winning type and channel of that cycle. A small two-state machine drives the request line: state QUIET (line high) and state ASSERT (line low). The transition QUIET to ASSERT (named RAISE) is taken on the clock edge at which a qualifying winner exists; ASSERT to QUIET (named WITHDRAW) is taken on the edge at which none exists. There is no clear operation: withdrawing a request is the only way the line returns high.

Register map (byte wide, 6-bit address): 0x00 mask for channels 0 and 1, 0x01 mask for channels 2 and 3, 0x02 control (bits 2:0 threshold, bits 6:4 counter/timer level), 0x04 to 0x07 level registers of channels 0 to 3 (bits 2:0 used), 0x08 source register (read only), 0x2A update command (write only). Unlisted addresses read 0x00.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset irq_n is 1 and the source register (0x08), the control register (0x02) and the four level registers (0x04 to 0x07) all read 0x00.
- R2: The mask registers read 0x00 at all times. In a mask register, bits 0, 1, 2 enable transmit, receive, change-of-state of the even channel of the pair, bits 3, 4, 5 the same for the odd channel, and bit 6 of the mask at 0x00 enables the counter/timer; a request whose enable bit is 0 takes no part in arbitration.
- R3: A channel request bids {level, type}, with type code 3 for receive, 2 for transmit, 1 for change-of-state; the counter/timer bids {control bits 6:4, 0}. The highest bid among enabled pending requests wins.
- R4: irq_n goes to 0 one clock after a winner exists whose level is strictly greater than the threshold; if the winning level is equal to or below the threshold, or all levels and the threshold are 0, irq_n stays 1.
- R5: When two channels place equal bids, the lower channel number wins.
- R6: The source register is loaded only on a write to 0x2A or on an acknowledge pulse, with bit 7 = 1, bits 3:2 = winner type code, bits 1:0 = winner channel (0 for the counter/timer), bits 6:4 = 0; it holds its value in every other cycle.
- R7: An update made while no winner passes the threshold loads 0x00 into the source register.
- R8: irq_n returns to 1 one clock after the qualifying requests drop or are masked, with no clear operation.
- R9: The control and level registers read back all eight bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| iack | input | 1 | Acknowledge pulse, loads the source register |
| tx_req | input | 4 | Transmit requests, one per channel |
| rx_req | input | 4 | Receive requests, one per channel |
| cos_req | input | 4 | Change-of-state requests, one per channel |
| tmr_req | input | 1 | Counter/timer request |
| irq_n | output | 1 | Active-low interrupt request to the host |

## Verification
The assertions take for granted that the request inputs are level signals held for whole clock cycles and that a write strobe and an acknowledge pulse each last one cycle; the source-register hold check also relies on the host not writing 0x2A except as an update command. The stimulus changes requests and register port signals a quarter period after a rising edge, holds them until the next edge and drives each strobe for exactly one cycle. Scenarios cover zero levels, threshold equality, type ordering within a channel, equal bids across channels, a masked request, a stale source register and a counter/timer winner.

// File: rtl/uia_pkg.sv
package uia_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MASK0  = 6'h00;
    localparam logic [ADDR_W-1:0] A_MASK1  = 6'h01;
    localparam logic [ADDR_W-1:0] A_CTL    = 6'h02;
    localparam logic [ADDR_W-1:0] A_LVL0   = 6'h04;
    localparam logic [ADDR_W-1:0] A_SRC    = 6'h08;
    localparam logic [ADDR_W-1:0] A_UPDATE = 6'h2A;

    typedef enum logic [1:0] {
        SRC_TMR = 2'd0,
        SRC_COS = 2'd1,
        SRC_TX  = 2'd2,
        SRC_RX  = 2'd3
    } src_type_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ASSERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/uia_regs.sv
module uia_regs
    import uia_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int LVL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W-1:0]     src_reg,
    output logic [DATA_W-1:0]     rdata,
    output logic                  upd_cmd,
    output logic [NCH-1:0]        tx_en,
    output logic [NCH-1:0]        rx_en,
    output logic [NCH-1:0]        cos_en,
    output logic                  tmr_en,
    output logic [LVL_W-1:0]      thr,
    output logic [LVL_W-1:0]      tmr_lvl,
    output logic [NCH*LVL_W-1:0]  lvl_flat
);
    localparam int NPAIR = NCH / 2;

    logic [DATA_W-1:0] mask_q [NPAIR];
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] lvl_q  [NCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int p = 0; p < NPAIR; p++) mask_q[p] <= '0;
            for (int c = 0; c < NCH; c++)   lvl_q[c]  <= '0;
        end else if (wr) begin
            if (addr == A_CTL) ctl_q <= wdata;
            for (int p = 0; p < NPAIR; p++)
                if (addr == A_MASK0 + ADDR_W'(p)) mask_q[p] <= wdata;
            for (int c = 0; c < NCH; c++)
                if (addr == A_LVL0 + ADDR_W'(c)) lvl_q[c] <= wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_chan
            assign tx_en[g]  = mask_q[g/2][(g%2)*3 + 0];
            assign rx_en[g]  = mask_q[g/2][(g%2)*3 + 1];
            assign cos_en[g] = mask_q[g/2][(g%2)*3 + 2];
            assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g][LVL_W-1:0];
        end
    endgenerate

    assign tmr_en  = mask_q[0][6];
    assign thr     = ctl_q[LVL_W-1:0];
    assign tmr_lvl = ctl_q[4 +: LVL_W];
    assign upd_cmd = wr && (addr == A_UPDATE);

    always_comb begin
        rdata = '0;
        if (addr == A_CTL) rdata = ctl_q;
        if (addr == A_SRC) rdata = src_reg;
        for (int c = 0; c < NCH; c++)
            if (addr == A_LVL0 + ADDR_W'(c)) rdata = lvl_q[c];
    end

    // R2: masks are write-only from the host's point of view
    p_mask_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == A_MASK0) || (addr == A_MASK1)) |-> (rdata == '0));

    // R9: a write to a level register is visible in full on the next cycle
    p_lvl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_LVL0)) |=> (lvl_q[0] == $past(wdata)));
endmodule

// File: rtl/uia_arbiter.sv
module uia_arbiter
    import uia_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int LVL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        tx_req,
    input  logic [NCH-1:0]        rx_req,
    input  logic [NCH-1:0]        cos_req,
    input  logic                  tmr_req,
    input  logic [NCH-1:0]        tx_en,
    input  logic [NCH-1:0]        rx_en,
    input  logic [NCH-1:0]        cos_en,
    input  logic                  tmr_en,
    input  logic [LVL_W-1:0]      thr,
    input  logic [LVL_W-1:0]      tmr_lvl,
    input  logic [NCH*LVL_W-1:0]  lvl_flat,
    output logic                  win_valid,
    output logic [1:0]            win_type,
    output logic [1:0]            win_ch
);
    localparam int BID_W = LVL_W + 2;
    localparam int NSRC  = 3 * NCH;

    logic [NSRC-1:0] src_act;
    logic [BID_W-1:0] src_bid  [NSRC];
    logic [1:0]       src_type [NSRC];
    logic [1:0]       src_ch   [NSRC];

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_src
            assign src_act[3*g+0]  = rx_req[g]  & rx_en[g];
            assign src_act[3*g+1]  = tx_req[g]  & tx_en[g];
            assign src_act[3*g+2]  = cos_req[g] & cos_en[g];
            assign src_type[3*g+0] = SRC_RX;
            assign src_type[3*g+1] = SRC_TX;
            assign src_type[3*g+2] = SRC_COS;
            for (genvar k = 0; k < 3; k++) begin : g_kind
                assign src_bid[3*g+k] = {lvl_flat[g*LVL_W +: LVL_W], src_type[3*g+k]};
                assign src_ch[3*g+k]  = 2'(g);
            end
        end
    endgenerate

    logic             best_act;
    logic [BID_W-1:0] best_bid;
    logic [1:0]       best_type;
    logic [1:0]       best_ch;

    always_comb begin
        best_act  = tmr_req & tmr_en;
        best_bid  = {tmr_lvl, SRC_TMR};
        best_type = SRC_TMR;
        best_ch   = 2'd0;
        // scan upward; strict compare keeps the lower channel on a tie (R5)
        for (int s = 0; s < NSRC; s++) begin
            if (src_act[s] && (!best_act || (src_bid[s] > best_bid))) begin
                best_act  = 1'b1;
                best_bid  = src_bid[s];
                best_type = src_type[s];
                best_ch   = src_ch[s];
            end
        end
    end

    assign win_valid = best_act && (best_bid[BID_W-1:2] > thr);
    assign win_type  = best_type;
    assign win_ch    = best_ch;

    // R4: all levels zero can never produce a qualifying winner
    p_zero_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_flat == '0) && (tmr_lvl == '0)) |-> !win_valid);

    // R2: a winner always comes from some enabled pending request
    p_win_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((src_act != '0) || (tmr_req && tmr_en)));
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uia_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              iack,
    input  logic [NCH-1:0]    tx_req,
    input  logic [NCH-1:0]    rx_req,
    input  logic [NCH-1:0]    cos_req,
    input  logic              tmr_req,
    output logic              irq_n
);
    logic [NCH-1:0]       tx_en, rx_en, cos_en;
    logic                 tmr_en;
    logic [LVL_W-1:0]     thr, tmr_lvl;
    logic [NCH*LVL_W-1:0] lvl_flat;
    logic                 upd_cmd, upd;
    logic                 win_valid;
    logic [1:0]           win_type, win_ch;
    logic [DATA_W-1:0]    src_q;
    irq_state_e           state_q, state_d;

    uia_regs #(.NCH(NCH), .LVL_W(LVL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .src_reg(src_q), .rdata(reg_rdata),
        .upd_cmd(upd_cmd), .tx_en(tx_en), .rx_en(rx_en), .cos_en(cos_en),
        .tmr_en(tmr_en), .thr(thr), .tmr_lvl(tmr_lvl), .lvl_flat(lvl_flat)
    );

    uia_arbiter #(.NCH(NCH), .LVL_W(LVL_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
        .cos_req(cos_req), .tmr_req(tmr_req), .tx_en(tx_en), .rx_en(rx_en),
        .cos_en(cos_en), .tmr_en(tmr_en), .thr(thr), .tmr_lvl(tmr_lvl),
        .lvl_flat(lvl_flat), .win_valid(win_valid), .win_type(win_type),
        .win_ch(win_ch)
    );

    assign upd = upd_cmd | iack;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // transitions: RAISE (QUIET->ASSERT), WITHDRAW (ASSERT->QUIET)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (win_valid)  state_d = ST_ASSERT;
            ST_ASSERT: if (!win_valid) state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_QUIET:  irq_n = 1'b1;
            ST_ASSERT: irq_n = 1'b0;
        endcase
    end

    // source register: captured only on update command or acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)   src_q <= '0;
        else if (upd) src_q <= win_valid ? {1'b1, 3'b000, win_type, win_ch} : '0;
    end

    p_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr || iack) |=> $stable(src_q));

    p_src_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !win_valid) |=> (src_q == '0));

    p_irq_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !irq_n);

    p_irq_withdraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> irq_n);
endmodule

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb_top;
    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] reg_addr = 6'h08;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       iack = 1'b0;
    logic [3:0] tx_req = '0, rx_req = '0, cos_req = '0;
    logic       tmr_req = 1'b0;
    logic       irq_n;

    int compared = 0;
    int mismatched = 0;

    uart_irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iack(iack),
        .tx_req(tx_req), .rx_req(rx_req), .cos_req(cos_req),
        .tmr_req(tmr_req), .irq_n(irq_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    int m_mask [2];
    int m_ctl;
    int m_lvl [4];
    int m_src;
    bit m_irq_n;

    function automatic int req_bit(int kind, int c);
        case (kind)
            0: return int'(tx_req[c]);
            1: return int'(rx_req[c]);
            default: return int'(cos_req[c]);
        endcase
    endfunction

    // returns source code, 0 if nothing passes the threshold
    function automatic int model_winner();
        int best = -1;
        int code = 0;
        int tcode [3] = '{2, 3, 1};
        for (int c = NCH - 1; c >= 0; c--)
            for (int k = 0; k < 3; k++) begin
                int en  = (m_mask[c/2] >> ((c%2)*3 + k)) & 1;
                int bid = (m_lvl[c] & 7) * 4 + tcode[k];
                if (en == 1 && req_bit(k, c) == 1 && bid >= best) begin
                    best = bid;
                    code = 128 + tcode[k] * 4 + c;
                end
            end
        if (tmr_req && ((m_mask[0] >> 6) & 1) == 1 && ((m_ctl >> 4) & 7) * 4 > best) begin
            best = ((m_ctl >> 4) & 7) * 4;
            code = 128;
        end
        if (best < 0 || (best / 4) <= (m_ctl & 7)) return 0;
        return code;
    endfunction

    function automatic int model_read(int a);
        if (a == 2) return m_ctl;
        if (a == 8) return m_src;
        if (a >= 4 && a <= 7) return m_lvl[a-4];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask[0] <= 0; m_mask[1] <= 0; m_ctl <= 0; m_src <= 0; m_irq_n <= 1'b1;
            for (int c = 0; c < 4; c++) m_lvl[c] <= 0;
        end else begin
            int w;
            w = model_winner();
            m_irq_n <= (w == 0);
            if ((reg_wr && reg_addr == 6'h2A) || iack) m_src <= w;
            if (reg_wr) begin
                if (reg_addr == 6'h00) m_mask[0] <= int'(reg_wdata);
                if (reg_addr == 6'h01) m_mask[1] <= int'(reg_wdata);
                if (reg_addr == 6'h02) m_ctl <= int'(reg_wdata);
                if (reg_addr >= 6'h04 && reg_addr <= 6'h07) m_lvl[reg_addr-4] <= int'(reg_wdata);
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (irq_n !== m_irq_n) begin
                mismatched++;
                $display("FAIL R4 R8 irq_n actual=%0b expected=%0b at %0t", irq_n, m_irq_n, $time);
            end
            compared++;
            if (int'(reg_rdata) != model_read(int'(reg_addr))) begin
                mismatched++;
                $display("FAIL R6 rdata@%0h actual=%0h expected=%0h at %0t",
                         reg_addr, reg_rdata, model_read(int'(reg_addr)), $time);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(posedge clk); #(CLK_P/4);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #(CLK_P/4);
        reg_wr = 1'b0; reg_addr = 6'h08;
    endtask

    task automatic pulse_iack();
        @(posedge clk); #(CLK_P/4);
        iack = 1'b1;
        @(posedge clk); #(CLK_P/4);
        iack = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [5:0] a, int exp);
        @(posedge clk); #(CLK_P/4);
        reg_addr = a;
        #1;
        check(tag, int'(reg_rdata), exp);
        reg_addr = 6'h08;
    endtask

    initial begin
        #(CLK_P * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 irq_n", int'(irq_n), 1);
        rd_check("R1 source", 6'h08, 8'h00);
        rd_check("R1 control", 6'h02, 8'h00);
        rd_check("R1 level0", 6'h04, 8'h00);
        rd_check("R1 level3", 6'h07, 8'h00);

        // R2 masks write-only; R4 zero levels give no request
        wr(6'h00, 8'h7F);
        wr(6'h01, 8'h3F);
        rd_check("R2 mask0 read", 6'h00, 8'h00);
        rd_check("R2 mask1 read", 6'h01, 8'h00);
        @(posedge clk); #(CLK_P/4); rx_req[1] = 1'b1;
        idle(3);
        check("R4 zero levels irq_n", int'(irq_n), 1);

        // R4 level above threshold raises; R3 R6 source capture
        wr(6'h05, 8'h02);
        idle(2);
        check("R4 level over threshold irq_n", int'(irq_n), 0);
        wr(6'h2A, 8'h00);
        rd_check("R6 source rx ch1", 6'h08, 8'h8D);

        // R4 equal to threshold does not qualify; R7 empty update
        wr(6'h02, 8'h02);
        idle(2);
        check("R4 level equal threshold irq_n", int'(irq_n), 1);
        wr(6'h2A, 8'h00);
        rd_check("R7 empty update", 6'h08, 8'h00);

        // R3 receive beats transmit at same level
        wr(6'h02, 8'h00);
        wr(6'h04, 8'h02);
        @(posedge clk); #(CLK_P/4); tx_req[0] = 1'b1;
        wr(6'h2A, 8'h00);
        rd_check("R3 rx over tx", 6'h08, 8'h8D);

        // R5 equal bids, lower channel wins; R6 acknowledge pulse
        @(posedge clk); #(CLK_P/4); rx_req[0] = 1'b1;
        pulse_iack();
        rd_check("R5 tie lower channel", 6'h08, 8'h8C);

        // R2 masked request ignored
        wr(6'h00, 8'h7D);
        wr(6'h2A, 8'h00);
        rd_check("R2 masked rx ch0", 6'h08, 8'h8D);

        // R6 source register stale without update
        @(posedge clk); #(CLK_P/4); rx_req[1] = 1'b0;
        idle(2);
        rd_check("R6 hold without update", 6'h08, 8'h8D);

        // R8 withdrawal when requests drop
        @(posedge clk); #(CLK_P/4); tx_req[0] = 1'b0; rx_req[0] = 1'b0;
        idle(1);
        check("R8 withdraw irq_n", int'(irq_n), 1);

        // R3 counter/timer with its own level wins
        wr(6'h02, 8'h50);
        @(posedge clk); #(CLK_P/4); tmr_req = 1'b1; rx_req[1] = 1'b1;
        idle(2);
        check("R3 timer irq_n", int'(irq_n), 0);
        wr(6'h2A, 8'h00);
        rd_check("R3 timer source", 6'h08, 8'h80);

        // R9 full readback
        wr(6'h06, 8'hA5);
        rd_check("R9 level2 readback", 6'h06, 8'hA5);
        rd_check("R9 control readback", 6'h02, 8'h50);

        // R8 masking the timer withdraws too
        @(posedge clk); #(CLK_P/4); rx_req[1] = 1'b0;
        wr(6'h00, 8'h00);
        idle(1);
        check("R8 masked withdraw irq_n", int'(irq_n), 1);

        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule